// File: doc/BRIEF.md
# Double-Buffered 16-bit Output Compare Unit

This block watches a free-running 16-bit timer count supplied from outside and compares it, on every clock, against an active compare value. An equality match raises a compare flag one timer tick later. The flag can drive an interrupt request, and it can be cleared either by an interrupt acknowledge or by a write of one from software. The same match, together with the counter's TOP and BOTTOM strobes, drives a single waveform output. A 2-bit output-mode field selects whether that output holds, toggles, clears or sets.

Software loads the 16-bit compare value over an 8-bit bus. It first writes the high byte, which is staged in a temporary register. It then writes the low byte, which commits both bytes in one cycle. The committed word lands in a shadow buffer, and reading back returns that buffer. An update-class input says when the buffer reaches the active register:
- **Non-PWM class:** the active register takes the word at once.
- **PWM classes:** the copy waits for a timer tick that coincides with the TOP strobe or with the BOTTOM strobe, depending on the class.

Waiting for the strobe keeps every PWM period whole.

Top module: `dbcmp_top`

## Requirements
- R1: After reset the read-back word, the active compare value, the flag, the interrupt request and the waveform output are all zero.
- R2: A high-byte write alone (`wr_hi`) changes neither the read-back word nor the active compare value.
- R3: A low-byte write (`wr_lo`) makes the read-back word equal {staged high byte, bus byte} on the next cycle.
- R4: With `upd_sel` = 0 (non-PWM), a low-byte write sets the active compare value to the same new word on the next cycle.
- R5: With `upd_sel` = 1 (PWM, update at TOP), the active value holds through low-byte writes and BOTTOM strobes. It takes the buffer at the first clock where `tick` and `at_top` are both high.
- R6: With `upd_sel` = 2 (PWM, update at BOTTOM), the active value ignores TOP strobes. It takes the buffer only where `tick` and `at_bottom` are both high. A low-byte write in that same cycle is not seen by that transfer, which copies the previous buffer.
- R7: When the count equals the active value in a cycle with `tick` high, the flag rises at the clock edge of the next cycle that has `tick` high, and not earlier.
- R8: `irq_ack` or `flag_wr1` clears the flag at the next edge. If a set falls in the same cycle, the set wins.
- R9: `irq_req` is high exactly when the flag is high and `irq_en` is 1.
- R10: At a matching tick, `out_mode` 1 toggles the output, 2 clears it, 3 sets it, and 0 leaves it unchanged. The output changes at that same edge.
- R11: In either PWM class, a tick with `at_bottom` high and no match sets the output for `out_mode` 2 and clears it for `out_mode` 3. In the non-PWM class, BOTTOM has no effect on the output.
- R12: Cycles with `tick` low change neither the flag, the output nor the active value (bus writes in non-PWM excepted). A match seen only while `tick` is low never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| cnt_val | input | 16 | Current timer count |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| upd_sel | input | 2 | Update class: 0 non-PWM, 1 PWM at TOP, 2 PWM at BOTTOM |
| out_mode | input | 2 | Output action: 0 hold, 1 toggle, 2 clear, 3 set |
| bus_data | input | 8 | Bus write byte |
| wr_hi | input | 1 | Write high byte into the staging register |
| wr_lo | input | 1 | Write low byte and commit the word |
| flag_wr1 | input | 1 | Software write of one to the flag |
| irq_ack | input | 1 | Interrupt serviced |
| irq_en | input | 1 | Interrupt enable |
| cmp_rd | output | 16 | Read-back of the buffered compare word |
| cmp_active | output | 16 | Active compare value |
| cmp_flag | output | 1 | Compare flag |
| irq_req | output | 1 | Interrupt request |
| wave_out | output | 1 | Waveform output |

## Verification
The bench targets the transfer points. It checks that a PWM class ignores the wrong strobe, and that a low-byte write arriving together with the transfer strobe moves the old buffer. A design that mixed up the classes, or that passed the write straight through, would show a glitched period as an early active value.

It also checks the one-tick flag delay across gaps in `tick`, a set that coincides with a clear, and a match seen only while `tick` is low. A design that set the flag at once, or that sampled matches without `tick`, would flag early or spuriously.

For the BOTTOM action on the output, the bench uses the non-PWM class as the contrast. A design that applied the BOTTOM action there would wrongly drive the output high.

// File: rtl/dbcmp_pkg.sv
package dbcmp_pkg;

  typedef enum logic [1:0] {
    UPD_DIRECT = 2'd0,
    UPD_AT_TOP = 2'd1,
    UPD_AT_BOT = 2'd2,
    UPD_RSVD   = 2'd3
  } upd_cls_e;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_CLEAR  = 2'd2,
    OM_SET    = 2'd3
  } omode_e;

  function automatic logic f_is_pwm(upd_cls_e c);
    return (c == UPD_AT_TOP) || (c == UPD_AT_BOT);
  endfunction

  function automatic logic f_xfer(upd_cls_e c, logic tk, logic top, logic bot);
    logic ev;
    case (c)
      UPD_AT_TOP: ev = top;
      UPD_AT_BOT: ev = bot;
      default:    ev = 1'b0;
    endcase
    return tk & ev;
  endfunction

  function automatic logic f_wave_next(logic cur, omode_e m, logic hit,
                                       logic bot_evt, logic pwm);
    logic nxt;
    nxt = cur;
    if (hit) begin
      case (m)
        OM_TOGGLE: nxt = ~cur;
        OM_CLEAR:  nxt = 1'b0;
        OM_SET:    nxt = 1'b1;
        default:   nxt = cur;
      endcase
    end else if (pwm && bot_evt) begin
      case (m)
        OM_CLEAR: nxt = 1'b1;
        OM_SET:   nxt = 1'b0;
        default:  nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/dbcmp_loader.sv
module dbcmp_loader
  import dbcmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          at_top,
  input  logic          at_bottom,
  input  upd_cls_e      cls,
  input  logic [BW-1:0] bus_data,
  input  logic          wr_hi,
  input  logic          wr_lo,
  output logic [CW-1:0] buf_q,
  output logic [CW-1:0] act_q
);
  localparam int HW = CW - BW;

  logic [HW-1:0] temp_q;
  logic [CW-1:0] word_new;
  logic          pwm;
  logic          xfer_evt;

  assign word_new = {temp_q, bus_data};
  assign pwm      = f_is_pwm(cls);
  assign xfer_evt = f_xfer(cls, tick, at_top, at_bottom);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
    end else begin
      if (wr_hi) temp_q <= bus_data[HW-1:0];
      if (wr_lo) buf_q <= word_new;
      if (wr_lo && !pwm) act_q <= word_new;
      else if (xfer_evt) act_q <= buf_q;
    end
  end

  p_hi_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !xfer_evt) |=> ($stable(buf_q) && $stable(act_q)));

  p_lo_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (buf_q == {$past(temp_q), $past(bus_data)}));

  p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && cls == UPD_DIRECT) |=> (act_q == buf_q));

  p_top_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == UPD_AT_TOP && !(tick && at_top)) |=> $stable(act_q));

  p_bot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == UPD_AT_BOT && !(tick && at_bottom)) |=> $stable(act_q));

  p_idle_act_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo) |=> $stable(act_q));
endmodule

// File: rtl/dbcmp_flag.sv
module dbcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic irq_ack,
  input  logic flag_wr1,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_req
);
  logic pend_q;
  logic set_evt;
  logic clr_evt;

  assign set_evt = tick & pend_q;
  assign clr_evt = irq_ack | flag_wr1;
  assign irq_req = flag_q & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (tick) pend_q <= match;
      if (set_evt) flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
    end
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> flag_q);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !(tick && pend_q)) |=> !flag_q);

  p_flag_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_evt) |=> $stable(flag_q));
endmodule

// File: rtl/dbcmp_wave.sv
module dbcmp_wave
  import dbcmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     match,
  input  logic     at_bottom,
  input  upd_cls_e cls,
  input  omode_e   mode,
  output logic     wave_q
);
  logic hit;
  logic bot_evt;
  logic pwm;

  assign hit     = tick & match;
  assign bot_evt = tick & at_bottom;
  assign pwm     = f_is_pwm(cls);

  always_ff @(posedge clk) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= f_wave_next(wave_q, mode, hit, bot_evt, pwm);
  end

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == OM_TOGGLE) |=> (wave_q != $past(wave_q)));

  p_match_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == OM_SET) |=> wave_q);

  p_bot_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && bot_evt && !match && mode == OM_CLEAR) |=> wave_q);

  p_bot_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && !hit) |=> $stable(wave_q));

  p_wave_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_q));
endmodule

// File: rtl/dbcmp_top.sv
module dbcmp_top
  import dbcmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt_val,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic [1:0]    upd_sel,
  input  logic [1:0]    out_mode,
  input  logic [BW-1:0] bus_data,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          flag_wr1,
  input  logic          irq_ack,
  input  logic          irq_en,
  output logic [CW-1:0] cmp_rd,
  output logic [CW-1:0] cmp_active,
  output logic          cmp_flag,
  output logic          irq_req,
  output logic          wave_out
);
  upd_cls_e      cls;
  omode_e        mode;
  logic          match;
  logic [CW-1:0] act_w;

  assign cls        = upd_cls_e'(upd_sel);
  assign mode       = omode_e'(out_mode);
  assign match      = (cnt_val == act_w);
  assign cmp_active = act_w;

  dbcmp_loader #(.CW(CW), .BW(BW)) u_loader (
    .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
    .at_bottom(at_bottom), .cls(cls), .bus_data(bus_data),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .buf_q(cmp_rd), .act_q(act_w)
  );

  dbcmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
    .irq_ack(irq_ack), .flag_wr1(flag_wr1), .irq_en(irq_en),
    .flag_q(cmp_flag), .irq_req(irq_req)
  );

  dbcmp_wave u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
    .at_bottom(at_bottom), .cls(cls), .mode(mode), .wave_q(wave_out)
  );

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_flag || !irq_en) |-> !irq_req);
endmodule

// File: tb/test_dbcmp_top.sv
module test_dbcmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {wr_hi, wr_lo, data, upd_sel, at_top, at_bottom, exp_rd, exp_act}
  localparam logic [45:0] VT [0:NV-1] = '{
    {1'b1, 1'b0, 8'hAB, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 8'hCD, 2'd0, 1'b0, 1'b0, 16'hABCD, 16'hABCD},
    {1'b1, 1'b0, 8'h12, 2'd1, 1'b0, 1'b0, 16'hABCD, 16'hABCD},
    {1'b0, 1'b1, 8'h34, 2'd1, 1'b0, 1'b0, 16'h1234, 16'hABCD},
    {1'b0, 1'b0, 8'h00, 2'd1, 1'b0, 1'b1, 16'h1234, 16'hABCD},
    {1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 1'b0, 16'h1234, 16'h1234},
    {1'b1, 1'b0, 8'h56, 2'd2, 1'b0, 1'b0, 16'h1234, 16'h1234},
    {1'b0, 1'b1, 8'h78, 2'd2, 1'b0, 1'b0, 16'h5678, 16'h1234},
    {1'b0, 1'b0, 8'h00, 2'd2, 1'b1, 1'b0, 16'h5678, 16'h1234},
    {1'b0, 1'b0, 8'h00, 2'd2, 1'b0, 1'b1, 16'h5678, 16'h5678},
    {1'b1, 1'b0, 8'h9A, 2'd2, 1'b0, 1'b0, 16'h5678, 16'h5678},
    {1'b0, 1'b1, 8'hBC, 2'd2, 1'b0, 1'b1, 16'h9ABC, 16'h5678},
    {1'b0, 1'b0, 8'h00, 2'd2, 1'b0, 1'b1, 16'h9ABC, 16'h9ABC}
  };

  logic        clk = 1'b0;
  logic        rst_n, tick, at_top, at_bottom, wr_hi, wr_lo;
  logic        flag_wr1, irq_ack, irq_en;
  logic [15:0] cnt_val;
  logic [1:0]  upd_sel, out_mode;
  logic [7:0]  bus_data;
  logic [15:0] cmp_rd, cmp_active;
  logic        cmp_flag, irq_req, wave_out;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbcmp_top i_dbcmp_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
    .at_top(at_top), .at_bottom(at_bottom), .upd_sel(upd_sel),
    .out_mode(out_mode), .bus_data(bus_data), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .flag_wr1(flag_wr1), .irq_ack(irq_ack), .irq_en(irq_en),
    .cmp_rd(cmp_rd), .cmp_active(cmp_active), .cmp_flag(cmp_flag),
    .irq_req(irq_req), .wave_out(wave_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk); wr_hi = 1'b1; bus_data = w[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; bus_data = w[7:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; at_top = 1'b0; at_bottom = 1'b0;
    wr_hi = 1'b0; wr_lo = 1'b0; flag_wr1 = 1'b0; irq_ack = 1'b0;
    irq_en = 1'b0; cnt_val = 16'hFFFF; upd_sel = 2'd0; out_mode = 2'd0;
    bus_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd", cmp_rd, 16'h0);
    chk("R1 act", cmp_active, 16'h0);
    chk("R1 flag", {15'd0, cmp_flag}, 16'd0);
    chk("R1 irq", {15'd0, irq_req}, 16'd0);
    chk("R1 wave", {15'd0, wave_out}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // table: loading and transfer points (R2 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_hi, wr_lo, bus_data, upd_sel, at_top, at_bottom} = VT[i][45:32];
      edge_sample();
      chk($sformatf("R2-6 row%0d rd (R3)", i), cmp_rd, VT[i][31:16]);
      chk($sformatf("R2-6 row%0d act (R4 R5 R6)", i), cmp_active, VT[i][15:0]);
    end
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0; at_top = 1'b0; at_bottom = 1'b0; upd_sel = 2'd0;

    // flag timing R7, R9, R8
    load_word(16'h0010);
    chk("R4 direct", cmp_active, 16'h0010);
    cnt_val = 16'h0010;
    edge_sample();
    chk("R7 not yet", {15'd0, cmp_flag}, 16'd0);
    @(negedge clk); cnt_val = 16'hFFFF;
    edge_sample();
    chk("R7 set", {15'd0, cmp_flag}, 16'd1);
    chk("R9 masked", {15'd0, irq_req}, 16'd0);
    irq_en = 1'b1; #1;
    chk("R9 enabled", {15'd0, irq_req}, 16'd1);
    @(negedge clk); irq_ack = 1'b1;
    edge_sample();
    chk("R8 ack", {15'd0, cmp_flag}, 16'd0);
    @(negedge clk); irq_ack = 1'b0; cnt_val = 16'h0010;
    edge_sample();
    @(negedge clk); cnt_val = 16'hFFFF; tick = 1'b0;
    repeat (3) edge_sample();
    chk("R12 flag waits tick", {15'd0, cmp_flag}, 16'd0);
    @(negedge clk); tick = 1'b1;
    edge_sample();
    chk("R7 set on next tick", {15'd0, cmp_flag}, 16'd1);
    @(negedge clk); flag_wr1 = 1'b1;
    edge_sample();
    chk("R8 write one", {15'd0, cmp_flag}, 16'd0);
    @(negedge clk); flag_wr1 = 1'b0; cnt_val = 16'h0010; tick = 1'b0;
    repeat (3) edge_sample();
    @(negedge clk); cnt_val = 16'hFFFF; tick = 1'b1;
    edge_sample(); edge_sample();
    chk("R12 untick match", {15'd0, cmp_flag}, 16'd0);
    @(negedge clk); cnt_val = 16'h0010;
    edge_sample();
    @(negedge clk); cnt_val = 16'hFFFF; flag_wr1 = 1'b1;
    edge_sample();
    chk("R8 set wins", {15'd0, cmp_flag}, 16'd1);
    @(negedge clk); flag_wr1 = 1'b0;

    // waveform R10
    out_mode = 2'd1; cnt_val = 16'h0010;
    edge_sample();
    chk("R10 toggle up", {15'd0, wave_out}, 16'd1);
    @(negedge clk); cnt_val = 16'hFFFF;
    edge_sample();
    chk("R10 no match hold", {15'd0, wave_out}, 16'd1);
    @(negedge clk); cnt_val = 16'h0010;
    edge_sample();
    chk("R10 toggle down", {15'd0, wave_out}, 16'd0);
    @(negedge clk); out_mode = 2'd3;
    edge_sample();
    chk("R10 set", {15'd0, wave_out}, 16'd1);
    @(negedge clk); out_mode = 2'd0;
    edge_sample();
    chk("R10 hold", {15'd0, wave_out}, 16'd1);
    @(negedge clk); out_mode = 2'd2;
    edge_sample();
    chk("R10 clear", {15'd0, wave_out}, 16'd0);

    // BOTTOM action R11
    @(negedge clk); cnt_val = 16'hFFFF; upd_sel = 2'd1; at_bottom = 1'b1;
    edge_sample();
    chk("R11 pwm bottom set", {15'd0, wave_out}, 16'd1);
    @(negedge clk); out_mode = 2'd3;
    edge_sample();
    chk("R11 pwm bottom clear", {15'd0, wave_out}, 16'd0);
    @(negedge clk); upd_sel = 2'd0; out_mode = 2'd2;
    edge_sample();
    chk("R11 direct ignores bottom", {15'd0, wave_out}, 16'd0);
    @(negedge clk); at_bottom = 1'b0;

    // tick low R12
    out_mode = 2'd1; cnt_val = 16'h0010; tick = 1'b0;
    edge_sample(); edge_sample();
    chk("R12 wave idle", {15'd0, wave_out}, 16'd0);
    @(negedge clk); tick = 1'b1; cnt_val = 16'hFFFF; out_mode = 2'd0; upd_sel = 2'd1;
    load_word(16'h4321);
    chk("R5 held", cmp_active, 16'h0010);
    tick = 1'b0; at_top = 1'b1;
    edge_sample();
    chk("R12 no transfer", cmp_active, 16'h0010);
    @(negedge clk); tick = 1'b1;
    edge_sample();
    chk("R5 transfer", cmp_active, 16'h4321);
    @(negedge clk); at_top = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule